// File: doc/BRIEF.md
# Processor Status Word Unit

This block holds the processor status word for a 32-bit core and updates it from execution results. Each integer ALU result event refreshes the arithmetic flags: zero, overflow, carry, low-bit ("parity") and negative. Each floating-point result event refreshes only the NaN and infinity flags. Software in the system ring may load the whole word directly. Taking an interrupt records the interrupt's 3-bit identifier and always returns the core to the system ring. The packed word and each flag as a separate signal are presented to the rest of the core.

Privilege is tracked by a two-state ring machine:

- **RING_SYS** is the state after reset.
- **SYS_TO_USR**: a direct write taken in RING_SYS with the user-ring bit set, and no interrupt in the same cycle, moves the machine to RING_USR.
- **USR_TO_SYS**: taking an interrupt moves RING_USR back to RING_SYS.
- **SYS_HOLD** and **USR_HOLD** keep the current state in every other case.

In RING_USR, direct writes are refused. A refused write raises a one-cycle privilege-violation pulse. Because a user program cannot load the word, it cannot set the ring bit, enable paging or change interrupt enable.

Top module: `flags_unit`

## Requirements
- R1: After reset the flag word is all zero and `priv_fault` is low: system ring, paging off, interrupts queued.
- R2: The word layout is:
  - bits 2:0 last interrupt id
  - bit 3 interrupt enable
  - bit 4 zero
  - bit 5 overflow
  - bit 6 carry
  - bit 7 low-bit flag
  - bit 8 negative
  - bit 9 NaN
  - bit 10 infinity
  - bit 11 user ring
  - bit 12 memory-map enable
  
  Bits 31:13 always read zero, whatever is written to them.
- R3: An integer event sets Z when the result is all zeros and N from result bit 31. It copies V from `int_ovf` and C from `int_carry`. The new values appear on the word one clock after the event cycle.
- R4: The low-bit flag (bit 7) equals bit 0 of the last integer result, not XOR parity.
- R5: An integer event leaves NaN and infinity unchanged.
- R6: A floating-point event loads NaN from `fp_nan` and infinity from `fp_inf`, and leaves Z, V, C, P and N unchanged.
- R7: A direct write in the system ring loads bits 12:0 from `wr_data` one clock later.
- R8: A direct write while the user ring bit is set changes nothing. It raises `priv_fault` for exactly the following cycle.
- R9: Taking an interrupt loads bits 2:0 with `irq_id` and clears the user ring bit. All other bits keep their values.
- R10: When events share a cycle:
  - integer and floating-point events override a direct write for their own bits;
  - an interrupt overrides a direct write for the id and user ring bits.
- R11: Each individual flag output equals its bit in the word.
- R12: `priv_fault` is low in every cycle not preceded by a refused user write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_valid | input | 1 | Integer result event |
| int_result | input | 32 | Integer result value |
| int_carry | input | 1 | Integer carry-out |
| int_ovf | input | 1 | Integer overflow |
| fp_valid | input | 1 | Floating-point result event |
| fp_nan | input | 1 | FP result is NaN |
| fp_inf | input | 1 | FP result is infinite |
| wr_valid | input | 1 | Direct write request |
| wr_data | input | 32 | Direct write data |
| irq_take | input | 1 | Interrupt taken this cycle |
| irq_id | input | 3 | Identifier of the taken interrupt |
| flag_word | output | 32 | Packed status word |
| flag_irq_id | output | 3 | Last interrupt id |
| flag_irq_en | output | 1 | Interrupt enable |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_carry | output | 1 | Carry flag |
| flag_par | output | 1 | Low-bit flag |
| flag_neg | output | 1 | Negative flag |
| flag_nan | output | 1 | NaN flag |
| flag_inf | output | 1 | Infinity flag |
| flag_user | output | 1 | User ring active |
| flag_map | output | 1 | Memory-map enable |
| priv_fault | output | 1 | One-cycle privilege violation pulse |

## Verification
Every result of this block is due exactly one clock after the cycle in which its stimulus is presented. This covers the flag bits, the ring state and the `priv_fault` pulse. The bench drives each stimulus on a falling edge and holds it across one rising edge. It then compares the whole word and `priv_fault` at the next falling edge, against a model updated once per stimulus. Idle cycles are checked the same way, which confirms that the word holds its value and the fault pulse lasts one cycle only.

// File: rtl/flags_pkg.sv
package flags_pkg;
    localparam int ID_W    = 3;
    localparam int USED_W  = 13;
    localparam int B_IE    = 3;
    localparam int B_ZERO  = 4;
    localparam int B_OVF   = 5;
    localparam int B_CARRY = 6;
    localparam int B_PAR   = 7;
    localparam int B_NEG   = 8;
    localparam int B_NAN   = 9;
    localparam int B_INF   = 10;
    localparam int B_USER  = 11;
    localparam int B_MAP   = 12;

    typedef enum logic [0:0] {
        RING_SYS = 1'b0,
        RING_USR = 1'b1
    } ring_state_t;
endpackage

// File: rtl/flags_int_eval.sv
module flags_int_eval #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    output logic              is_zero,
    output logic              is_neg,
    output logic              low_bit
);
    always_comb begin
        is_zero = (result == '0);
        is_neg  = result[DATA_W-1];
        low_bit = result[0];
    end
endmodule

// File: rtl/flags_ring_fsm.sv
module flags_ring_fsm
    import flags_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_enter_user,
    input  logic irq_take,
    output logic user_mode
);
    ring_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RING_SYS: if (sys_enter_user && !irq_take) state_d = RING_USR;
            RING_USR: if (irq_take) state_d = RING_SYS;
            default:  state_d = RING_SYS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RING_SYS;
        else        state_q <= state_d;
    end

    always_comb begin
        user_mode = (state_q == RING_USR);
    end
endmodule

// File: rtl/flags_unit.sv
module flags_unit
    import flags_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_valid,
    input  logic [WORD_W-1:0] int_result,
    input  logic              int_carry,
    input  logic              int_ovf,
    input  logic              fp_valid,
    input  logic              fp_nan,
    input  logic              fp_inf,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              irq_take,
    input  logic [ID_W-1:0]   irq_id,
    output logic [WORD_W-1:0] flag_word,
    output logic [ID_W-1:0]   flag_irq_id,
    output logic              flag_irq_en,
    output logic              flag_zero,
    output logic              flag_ovf,
    output logic              flag_carry,
    output logic              flag_par,
    output logic              flag_neg,
    output logic              flag_nan,
    output logic              flag_inf,
    output logic              flag_user,
    output logic              flag_map,
    output logic              priv_fault
);
    localparam int RSVD_W = WORD_W - USED_W;

    logic [ID_W-1:0] id_q;
    logic ie_q, z_q, v_q, c_q, p_q, n_q, nan_q, inf_q, map_q, fault_q;
    logic ev_zero, ev_neg, ev_low;
    logic user_mode, sys_wr, usr_wr;

    flags_int_eval #(.DATA_W(WORD_W)) u_eval (
        .result  (int_result),
        .is_zero (ev_zero),
        .is_neg  (ev_neg),
        .low_bit (ev_low)
    );

    always_comb begin
        sys_wr = wr_valid && !user_mode;
        usr_wr = wr_valid &&  user_mode;
    end

    flags_ring_fsm u_ring (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_enter_user (sys_wr && wr_data[B_USER]),
        .irq_take       (irq_take),
        .user_mode      (user_mode)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0; ie_q <= 1'b0; z_q <= 1'b0; v_q <= 1'b0; c_q <= 1'b0;
            p_q <= 1'b0; n_q <= 1'b0; nan_q <= 1'b0; inf_q <= 1'b0;
            map_q <= 1'b0; fault_q <= 1'b0;
        end else begin
            if (sys_wr) begin
                id_q  <= wr_data[ID_W-1:0];
                ie_q  <= wr_data[B_IE];
                z_q   <= wr_data[B_ZERO];
                v_q   <= wr_data[B_OVF];
                c_q   <= wr_data[B_CARRY];
                p_q   <= wr_data[B_PAR];
                n_q   <= wr_data[B_NEG];
                nan_q <= wr_data[B_NAN];
                inf_q <= wr_data[B_INF];
                map_q <= wr_data[B_MAP];
            end
            if (int_valid) begin
                z_q <= ev_zero;
                v_q <= int_ovf;
                c_q <= int_carry;
                p_q <= ev_low;
                n_q <= ev_neg;
            end
            if (fp_valid) begin
                nan_q <= fp_nan;
                inf_q <= fp_inf;
            end
            if (irq_take) id_q <= irq_id;
            fault_q <= usr_wr;
        end
    end

    always_comb begin
        flag_word = {{RSVD_W{1'b0}}, map_q, user_mode, inf_q, nan_q, n_q,
                     p_q, c_q, v_q, z_q, ie_q, id_q};
        flag_irq_id = id_q;
        flag_irq_en = ie_q;
        flag_zero   = z_q;
        flag_ovf    = v_q;
        flag_carry  = c_q;
        flag_par    = p_q;
        flag_neg    = n_q;
        flag_nan    = nan_q;
        flag_inf    = inf_q;
        flag_user   = user_mode;
        flag_map    = map_q;
        priv_fault  = fault_q;
    end
endmodule

// File: rtl/flags_unit_chk.sv
module flags_unit_chk
    import flags_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_valid,
    input logic [WORD_W-1:0] int_result,
    input logic              int_carry,
    input logic              int_ovf,
    input logic              fp_valid,
    input logic              fp_nan,
    input logic              fp_inf,
    input logic              wr_valid,
    input logic [WORD_W-1:0] wr_data,
    input logic              irq_take,
    input logic [ID_W-1:0]   irq_id,
    input logic [WORD_W-1:0] flag_word,
    input logic              flag_zero,
    input logic              flag_ovf,
    input logic              flag_carry,
    input logic              flag_par,
    input logic              flag_neg,
    input logic              flag_nan,
    input logic              flag_inf,
    input logic              flag_user,
    input logic              flag_map,
    input logic              priv_fault
);
    localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << USED_W) - 1);

    // R3
    a_r3_int_flags: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |=> (flag_zero == ($past(int_result) == '0))
                   && (flag_neg == $past(int_result[WORD_W-1]))
                   && (flag_carry == $past(int_carry))
                   && (flag_ovf == $past(int_ovf)));

    // R4
    a_r4_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |=> flag_par == $past(int_result[0]));

    // R5
    a_r5_int_keeps_fp: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && !fp_valid && !wr_valid) |=> $stable({flag_nan, flag_inf}));

    // R6
    a_r6_fp_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && !int_valid && !wr_valid) |=>
            $stable({flag_zero, flag_ovf, flag_carry, flag_par, flag_neg})
            && flag_nan == $past(fp_nan) && flag_inf == $past(fp_inf));

    // R7
    a_r7_sys_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !flag_user && !int_valid && !fp_valid && !irq_take) |=>
            flag_word == ($past(wr_data) & LOW_MASK));

    // R8
    a_r8_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && flag_user && !int_valid && !fp_valid && !irq_take) |=>
            $stable(flag_word) && priv_fault);

    // R9
    a_r9_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !flag_user && flag_word[ID_W-1:0] == $past(irq_id));

    // R12
    a_r12_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> $past(wr_valid && flag_user));

    // R8: paging bit moves only through a system write
    a_r8_map_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_map != $past(flag_map)) |-> $past(wr_valid && !flag_user));
endmodule

bind flags_unit flags_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_valid(int_valid), .int_result(int_result),
    .int_carry(int_carry), .int_ovf(int_ovf), .fp_valid(fp_valid),
    .fp_nan(fp_nan), .fp_inf(fp_inf), .wr_valid(wr_valid), .wr_data(wr_data),
    .irq_take(irq_take), .irq_id(irq_id), .flag_word(flag_word),
    .flag_zero(flag_zero), .flag_ovf(flag_ovf), .flag_carry(flag_carry),
    .flag_par(flag_par), .flag_neg(flag_neg), .flag_nan(flag_nan),
    .flag_inf(flag_inf), .flag_user(flag_user), .flag_map(flag_map),
    .priv_fault(priv_fault)
);

// File: tb/flags_unit_tb_top.sv
`timescale 1ns/1ps
module flags_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_valid = 0, int_carry = 0, int_ovf = 0;
    logic [31:0] int_result = '0;
    logic        fp_valid = 0, fp_nan = 0, fp_inf = 0;
    logic        wr_valid = 0;
    logic [31:0] wr_data = '0;
    logic        irq_take = 0;
    logic [2:0]  irq_id = '0;
    logic [31:0] flag_word;
    logic [2:0]  flag_irq_id;
    logic        flag_irq_en, flag_zero, flag_ovf, flag_carry, flag_par, flag_neg;
    logic        flag_nan, flag_inf, flag_user, flag_map, priv_fault;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_w = '0;
    logic        exp_f = 1'b0;

    always #2 clk = ~clk;

    flags_unit dut_i (
        .clk(clk), .rst_n(rst_n), .int_valid(int_valid), .int_result(int_result),
        .int_carry(int_carry), .int_ovf(int_ovf), .fp_valid(fp_valid),
        .fp_nan(fp_nan), .fp_inf(fp_inf), .wr_valid(wr_valid), .wr_data(wr_data),
        .irq_take(irq_take), .irq_id(irq_id), .flag_word(flag_word),
        .flag_irq_id(flag_irq_id), .flag_irq_en(flag_irq_en),
        .flag_zero(flag_zero), .flag_ovf(flag_ovf), .flag_carry(flag_carry),
        .flag_par(flag_par), .flag_neg(flag_neg), .flag_nan(flag_nan),
        .flag_inf(flag_inf), .flag_user(flag_user), .flag_map(flag_map),
        .priv_fault(priv_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one cycle of stimulus, update the model, compare one clock later.
    task automatic step(input string tag,
                        input logic iv, input logic [31:0] res, input logic c, input logic o,
                        input logic fv, input logic nan, input logic inf,
                        input logic wv, input logic [31:0] wd,
                        input logic it, input logic [2:0] id);
        logic [31:0] w;
        logic f;
        int_valid = iv; int_result = res; int_carry = c; int_ovf = o;
        fp_valid = fv; fp_nan = nan; fp_inf = inf;
        wr_valid = wv; wr_data = wd; irq_take = it; irq_id = id;
        w = exp_w; f = 1'b0;
        if (wv) begin
            if (exp_w[11]) f = 1'b1;
            else w[12:0] = wd[12:0];
        end
        if (iv) begin
            w[4] = (res == 0); w[5] = o; w[6] = c; w[7] = res[0]; w[8] = res[31];
        end
        if (fv) begin
            w[9] = nan; w[10] = inf;
        end
        if (it) begin
            w[2:0] = id; w[11] = 1'b0;
        end
        exp_w = w; exp_f = f;
        @(posedge clk);
        @(negedge clk);
        int_valid = 0; fp_valid = 0; wr_valid = 0; irq_take = 0;
        check({tag, " word"}, flag_word, exp_w);
        check({tag, " priv_fault"}, {31'b0, priv_fault}, {31'b0, exp_f});
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset word", flag_word, 32'h0);
        check("R1 reset fault", {31'b0, priv_fault}, 32'h0);

        // R3 R4 R5: walking ones, carry/overflow combos, NaN/inf preset
        step("R6 fp preset", 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
        for (int b = 0; b < 32; b++)
            for (int k = 0; k < 4; k++)
                step("R3 R4 R5 walk", 1, 32'h1 << b, k[0], k[1], 0, 0, 0, 0, 0, 0, 0);
        step("R3 zero result", 1, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R4 all ones", 1, 32'hFFFF_FFFF, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R4 low bit not parity", 1, 32'h0000_0003, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R6: all FP combos keep integer flags
        for (int k = 0; k < 4; k++)
            step("R6 fp combo", 0, 0, 0, 0, 1, k[0], k[1], 0, 0, 0, 0);

        // R11: individual outputs
        check("R11 fields", {flag_map, flag_user, flag_inf, flag_nan, flag_neg, flag_par,
                             flag_carry, flag_ovf, flag_zero, flag_irq_en, flag_irq_id},
              {19'b0, exp_w[12:0]});

        // R2 R7 R8 R9: writes with reserved bits, user writes refused, irq exit
        for (int k = 0; k < 64; k++) begin
            logic [31:0] d;
            d = (k * 32'h9E37_79B9) ^ 32'hFFFF_E000;
            step("R2 R7 sys write", 0, 0, 0, 0, 0, 0, 0, 1, d, 0, 0);
            check("R11 fields", {flag_map, flag_user, flag_inf, flag_nan, flag_neg, flag_par,
                                 flag_carry, flag_ovf, flag_zero, flag_irq_en, flag_irq_id},
                  {19'b0, exp_w[12:0]});
            if (exp_w[11]) begin
                step("R8 user write", 0, 0, 0, 0, 0, 0, 0, 1, ~d, 0, 0);
                idle("R12 fault one cycle");
                step("R9 irq exit", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, k[2:0]);
            end
        end

        // R9: all ids, from user ring
        for (int i = 0; i < 8; i++) begin
            step("R7 enter user", 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1808, 0, 0);
            step("R9 irq id", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, i[2:0]);
        end

        // R10: same-cycle precedence
        step("R10 int over write", 1, 32'h8000_0000, 1, 0, 0, 0, 0, 1, 32'h0000_0030, 0, 0);
        step("R10 fp over write", 0, 0, 0, 0, 1, 0, 1, 1, 32'h0000_0200, 0, 0);
        step("R10 irq over write", 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0805, 1, 3'd2);
        step("R7 enter user", 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0800, 0, 0);
        step("R8 user write with int", 1, 32'h0, 0, 0, 0, 0, 0, 1, 32'h0000_1000, 0, 0);
        step("R8 user write with irq", 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1FFF, 1, 3'd6);
        idle("R12 idle");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule